// File: doc/BRIEF.md
# USB Endpoint STALL Control

This block decides, for each endpoint of a USB device controller, whether the handshake generator should answer the current token with a STALL. It covers one control endpoint (endpoint 0) and a parameterised set of non-control endpoints (endpoints 1 to NUM_EP-1; six endpoints in total by default). Firmware writes per-endpoint STALL request bits. The token engine reports SETUP detection on endpoint 0 and completed IN/OUT transactions on the other endpoints. A request decoder supplies Set Feature and Clear Feature (ENDPOINT_HALT) events with a 4-bit endpoint number.

Endpoint 0 is simple. It stalls while its request bit is set, and the next SETUP releases it.

Each non-control endpoint has three pieces of state:
- a request bit, which firmware can read back;
- a latched halt status, set by the first transaction that meets the request bit or by a Set Feature;
- a record of whether the host caused the halt.

A global mode input selects who clears the request bit: firmware or hardware. Every output is registered. A stimulus sampled at clock edge k is visible on the outputs just after edge k.

Top module: `usb_ep_stall_ctl`

## Requirements
- R1: `rst` and `bus_reset_i` each force every request bit, halt status and host-halt record to 0. Both outputs read all zeros after that edge. `bus_reset_i` overrides any coincident event or write.
- R2: For endpoint 0, a write (`sw_we_i[0]`=1) loads `sw_wdata_i[0]` into `stall_bits_o[0]`, and `stall_resp_o[0]` always equals `stall_bits_o[0]`.
- R3: A `setup_det_i` pulse clears endpoint 0's request bit, even when a write of 1 to endpoint 0 arrives in the same cycle.
- R4: For endpoint n≥1, writing 1 sets `stall_bits_o[n]` and raises `stall_resp_o[n]`, but does not latch the halt status. If no transaction has arrived, a later write of 0 drops `stall_resp_o[n]` in either mode.
- R5: A pulse on `xact_i[n]` while endpoint n's request bit is 1 latches its halt status. In hardware-clear mode (`hw_clr_mode_i`=1) a later write of 0 clears `stall_bits_o[n]`, while `stall_resp_o[n]` stays 1.
- R6: A pulse on `xact_i[n]` while endpoint n's request bit is 0 changes nothing.
- R7: In software-clear mode (`hw_clr_mode_i`=0), writing 0 to endpoint n clears both its request bit and a halt status latched by a transaction.
- R8: A Set Feature for endpoint n sets its halt status and raises `stall_resp_o[n]` without touching `stall_bits_o[n]`. Writes cannot release that halt; only a Clear Feature can. If Set Feature and Clear Feature name the same endpoint in one cycle, Set Feature wins.
- R9: A Clear Feature for endpoint n clears its halt status. In hardware-clear mode it also clears the request bit. In software-clear mode the request bit keeps its value, so `stall_resp_o[n]` stays 1 while that bit is 1.
- R10: Feature events that name endpoint 0, or an endpoint number of NUM_EP or above, have no effect.
- R11: If a hardware event for an endpoint coincides with a firmware write to that endpoint, the write is discarded. Hardware events are a Set Feature, a Clear Feature, SETUP on endpoint 0, or a transaction that latches the halt.
- R12: `stall_bits_o[n]` is the request bit. For n≥1, `stall_resp_o[n]` is the request bit OR the halt status. Both outputs come from registers, so they update exactly one clock edge after the stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | USB bus reset seen, clears all stall state |
| hw_clr_mode_i | input | 1 | 1: hardware clears request bits on Clear Feature; 0: firmware clears them |
| sw_we_i | input | NUM_EP | Per-endpoint write strobe for the request bits |
| sw_wdata_i | input | NUM_EP | Values written with `sw_we_i` |
| setup_det_i | input | 1 | SETUP stage detected on endpoint 0 |
| xact_i | input | NUM_EP-1 (bits NUM_EP-1:1) | IN/OUT transaction on endpoint n, index = endpoint number |
| feat_set_i | input | 1 | Set Feature (ENDPOINT_HALT) decoded |
| feat_clr_i | input | 1 | Clear Feature (ENDPOINT_HALT) decoded |
| feat_ep_i | input | EPNUM_W | Endpoint number carried by the feature event |
| stall_bits_o | output | NUM_EP | Readable request bits |
| stall_resp_o | output | NUM_EP | Answer tokens on endpoint n with STALL |

## Verification
The hardest states to reach are those where a firmware write collides with a hardware event on the same endpoint in the same cycle. The same is true where the latched halt status differs from the readable request bit, because the status itself is never visible at the ports. The stimulus makes the status visible through `stall_resp_o` after the request bit has been cleared. It reaches each such state with directed cycles: arm the bit, deliver a transaction, then write 0 in each clear mode. Collisions are driven by asserting the write strobe in the very cycle of a transaction, a Clear Feature or a SETUP.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;

  // Per-endpoint state of a non-control endpoint
  typedef struct packed {
    logic req;   // request bit, readable by firmware
    logic halt;  // latched halt status
    logic host;  // halt was placed by a Set Feature
  } epn_state_t;

  localparam int unsigned USB_EPNUM_W = 4;

endpackage

// File: rtl/stall_feat_decode.sv
module stall_feat_decode #(
  parameter int unsigned NUM_EP  = 6,
  parameter int unsigned EPNUM_W = 4
) (
  input  logic               feat_set_i,
  input  logic               feat_clr_i,
  input  logic [EPNUM_W-1:0] feat_ep_i,
  output logic [NUM_EP-1:1]  set_hit_o,
  output logic [NUM_EP-1:1]  clr_hit_o
);

  // Only endpoints 1..NUM_EP-1 can be halted by the host
  for (genvar g = 1; g < NUM_EP; g++) begin : g_dec
    logic match;
    assign match        = (feat_ep_i == EPNUM_W'(g));
    assign set_hit_o[g] = feat_set_i & match;
    assign clr_hit_o[g] = feat_clr_i & match;
  end

endmodule

// File: rtl/stall_ep0_ctl.sv
module stall_ep0_ctl (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic setup_det_i,
  input  logic sw_we_i,
  input  logic sw_wd_i,
  output logic stall_bit_o,
  output logic stall_resp_o
);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (bus_reset_i)      req_d = 1'b0;
    else if (setup_det_i) req_d = 1'b0;   // new SETUP releases the stall
    else if (sw_we_i)     req_d = sw_wd_i;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_d;
  end

  assign stall_bit_o  = req_q;
  assign stall_resp_o = req_q;

endmodule

// File: rtl/stall_epn_ctl.sv
module stall_epn_ctl
  import usb_stall_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic hw_clr_mode_i,
  input  logic sw_we_i,
  input  logic sw_wd_i,
  input  logic xact_i,
  input  logic set_hit_i,
  input  logic clr_hit_i,
  output logic stall_bit_o,
  output logic stall_resp_o
);

  epn_state_t st_q, st_d;
  logic       resp_q;

  // Priority: bus reset, host set, host clear, transaction latch, firmware write
  always_comb begin
    st_d = st_q;
    if (bus_reset_i) begin
      st_d = '0;
    end else if (set_hit_i) begin
      st_d.halt = 1'b1;
      st_d.host = 1'b1;
    end else if (clr_hit_i) begin
      st_d.halt = 1'b0;
      st_d.host = 1'b0;
      if (hw_clr_mode_i) st_d.req = 1'b0;
    end else if (xact_i && st_q.req) begin
      st_d.halt = 1'b1;
    end else if (sw_we_i) begin
      st_d.req = sw_wd_i;
      if (!sw_wd_i && !hw_clr_mode_i && !st_q.host) st_d.halt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      resp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      resp_q <= st_d.req | st_d.halt;
    end
  end

  assign stall_bit_o  = st_q.req;
  assign stall_resp_o = resp_q;

endmodule

// File: rtl/usb_ep_stall_ctl.sv
module usb_ep_stall_ctl
  import usb_stall_pkg::*;
#(
  parameter int unsigned NUM_EP  = 6,
  parameter int unsigned EPNUM_W = USB_EPNUM_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_reset_i,
  input  logic               hw_clr_mode_i,
  input  logic [NUM_EP-1:0]  sw_we_i,
  input  logic [NUM_EP-1:0]  sw_wdata_i,
  input  logic               setup_det_i,
  input  logic [NUM_EP-1:1]  xact_i,
  input  logic               feat_set_i,
  input  logic               feat_clr_i,
  input  logic [EPNUM_W-1:0] feat_ep_i,
  output logic [NUM_EP-1:0]  stall_bits_o,
  output logic [NUM_EP-1:0]  stall_resp_o
);

  logic [NUM_EP-1:1] set_hit, clr_hit;

  stall_feat_decode #(
    .NUM_EP  (NUM_EP),
    .EPNUM_W (EPNUM_W)
  ) u_dec (
    .feat_set_i (feat_set_i),
    .feat_clr_i (feat_clr_i),
    .feat_ep_i  (feat_ep_i),
    .set_hit_o  (set_hit),
    .clr_hit_o  (clr_hit)
  );

  stall_ep0_ctl u_ep0 (
    .clk          (clk),
    .rst          (rst),
    .bus_reset_i  (bus_reset_i),
    .setup_det_i  (setup_det_i),
    .sw_we_i      (sw_we_i[0]),
    .sw_wd_i      (sw_wdata_i[0]),
    .stall_bit_o  (stall_bits_o[0]),
    .stall_resp_o (stall_resp_o[0])
  );

  for (genvar g = 1; g < NUM_EP; g++) begin : g_epn
    stall_epn_ctl u_epn (
      .clk           (clk),
      .rst           (rst),
      .bus_reset_i   (bus_reset_i),
      .hw_clr_mode_i (hw_clr_mode_i),
      .sw_we_i       (sw_we_i[g]),
      .sw_wd_i       (sw_wdata_i[g]),
      .xact_i        (xact_i[g]),
      .set_hit_i     (set_hit[g]),
      .clr_hit_i     (clr_hit[g]),
      .stall_bit_o   (stall_bits_o[g]),
      .stall_resp_o  (stall_resp_o[g])
    );
  end

endmodule

// File: rtl/usb_ep_stall_ctl_chk.sv
module usb_ep_stall_ctl_chk #(
  parameter int unsigned NUM_EP  = 6,
  parameter int unsigned EPNUM_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_reset_i,
  input logic               hw_clr_mode_i,
  input logic [NUM_EP-1:0]  sw_we_i,
  input logic [NUM_EP-1:0]  sw_wdata_i,
  input logic               setup_det_i,
  input logic [NUM_EP-1:1]  xact_i,
  input logic               feat_set_i,
  input logic               feat_clr_i,
  input logic [EPNUM_W-1:0] feat_ep_i,
  input logic [NUM_EP-1:0]  stall_bits_o,
  input logic [NUM_EP-1:0]  stall_resp_o
);

  a_r1_bus_reset_clears: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> (stall_bits_o == '0) && (stall_resp_o == '0));

  a_r3_setup_releases_ep0: assert property (@(posedge clk) disable iff (rst)
    setup_det_i |=> !stall_bits_o[0]);

  a_r2_ep0_resp_follows_bit: assert property (@(posedge clk) disable iff (rst)
    stall_resp_o[0] == stall_bits_o[0]);

  for (genvar k = 1; k < NUM_EP; k++) begin : g_chk
    a_r12_bit_implies_resp: assert property (@(posedge clk) disable iff (rst)
      stall_bits_o[k] |-> stall_resp_o[k]);

    a_r8_set_feature_halts: assert property (@(posedge clk) disable iff (rst)
      (feat_set_i && feat_ep_i == EPNUM_W'(k) && !bus_reset_i) |=> stall_resp_o[k]);

    a_r9_hw_clear_feature: assert property (@(posedge clk) disable iff (rst)
      (feat_clr_i && feat_ep_i == EPNUM_W'(k) && hw_clr_mode_i &&
       !(feat_set_i && feat_ep_i == EPNUM_W'(k))) |=> (!stall_bits_o[k] && !stall_resp_o[k]));

    a_r6_idle_xact_no_effect: assert property (@(posedge clk) disable iff (rst)
      (xact_i[k] && !stall_bits_o[k] && !stall_resp_o[k] && !sw_we_i[k] &&
       !((feat_set_i || feat_clr_i) && feat_ep_i == EPNUM_W'(k)))
      |=> (!stall_bits_o[k] && !stall_resp_o[k]));
  end

endmodule

bind usb_ep_stall_ctl usb_ep_stall_ctl_chk #(
  .NUM_EP  (NUM_EP),
  .EPNUM_W (EPNUM_W)
) u_chk (.*);

// File: tb/tb_usb_ep_stall_ctl.sv
`timescale 1ns/1ps
module tb_usb_ep_stall_ctl;

  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_reset_i = 1'b0;
  logic         hw_clr_mode_i = 1'b0;
  logic [N-1:0] sw_we_i = '0;
  logic [N-1:0] sw_wdata_i = '0;
  logic         setup_det_i = 1'b0;
  logic [N-1:1] xact_i = '0;
  logic         feat_set_i = 1'b0;
  logic         feat_clr_i = 1'b0;
  logic [3:0]   feat_ep_i = '0;
  logic [N-1:0] stall_bits_o, stall_resp_o;

  always #2.5 clk = ~clk;  // 200 MHz

  usb_ep_stall_ctl #(.NUM_EP(N), .EPNUM_W(4)) dut (.*);

  typedef struct {
    logic [N-1:0] bits;
    logic [N-1:0] resp;
    string        tag;
  } exp_t;

  exp_t sb_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // Monitor: outputs settle after the posedge, compared at the negedge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      vectors++;
      if (stall_bits_o !== e.bits || stall_resp_o !== e.resp) begin
        miscompares++;
        $display("FAIL %s: bits=%b resp=%b expected bits=%b resp=%b",
                 e.tag, stall_bits_o, stall_resp_o, e.bits, e.resp);
      end
    end
  end

  // Driver: caller sets inputs at a negedge, one edge is consumed, pulses drop
  task automatic cyc(input logic [N-1:0] eb, input logic [N-1:0] er, input string tag);
    exp_t e;
    @(posedge clk);
    e.bits = eb; e.resp = er; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    sw_we_i = '0; sw_wdata_i = '0; setup_det_i = 1'b0; xact_i = '0;
    feat_set_i = 1'b0; feat_clr_i = 1'b0; bus_reset_i = 1'b0;
  endtask

  task automatic wr(input int ep, input logic v);
    sw_we_i[ep] = 1'b1; sw_wdata_i[ep] = v;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    cyc('0, '0, "R1 reset state");
    rst = 1'b0;
    cyc('0, '0, "R1 idle after reset");

    // software-clear mode
    hw_clr_mode_i = 1'b0;
    wr(0, 1);                     cyc(6'b000001, 6'b000001, "R2 ep0 set");
    setup_det_i = 1;              cyc(6'b000000, 6'b000000, "R3 setup clears ep0");
    wr(0, 1); setup_det_i = 1;    cyc(6'b000000, 6'b000000, "R3 R11 setup beats write");
    wr(0, 1);                     cyc(6'b000001, 6'b000001, "R2 ep0 set again");
    wr(0, 0);                     cyc(6'b000000, 6'b000000, "R2 ep0 cleared by write");

    wr(1, 1);                     cyc(6'b000010, 6'b000010, "R4 ep1 set");
    wr(1, 0);                     cyc(6'b000000, 6'b000000, "R4 no halt latched");
    wr(1, 1);                     cyc(6'b000010, 6'b000010, "R4 ep1 set");
    xact_i[1] = 1;                cyc(6'b000010, 6'b000010, "R5 xact latches halt");
    wr(1, 0);                     cyc(6'b000000, 6'b000000, "R7 sw mode write0 clears all");
    xact_i[2] = 1;                cyc(6'b000000, 6'b000000, "R6 xact on idle ep2");

    feat_set_i = 1; feat_ep_i = 2; cyc(6'b000000, 6'b000100, "R8 set feature ep2");
    wr(2, 1);                     cyc(6'b000100, 6'b000100, "R8 write1 on halted ep2");
    wr(2, 0);                     cyc(6'b000000, 6'b000100, "R8 write0 cannot release");
    feat_clr_i = 1; feat_ep_i = 2; cyc(6'b000000, 6'b000000, "R9 clear feature ep2");

    wr(3, 1);                     cyc(6'b001000, 6'b001000, "R4 ep3 set");
    xact_i[3] = 1;                cyc(6'b001000, 6'b001000, "R5 ep3 latched");
    feat_clr_i = 1; feat_ep_i = 3; cyc(6'b001000, 6'b001000, "R9 sw mode keeps bit");
    wr(3, 0);                     cyc(6'b000000, 6'b000000, "R7 ep3 released");

    // hardware-clear mode
    hw_clr_mode_i = 1'b1;
    wr(4, 1);                     cyc(6'b010000, 6'b010000, "R4 ep4 set hw mode");
    wr(4, 0);                     cyc(6'b000000, 6'b000000, "R4 hw mode no halt");
    wr(4, 1);                     cyc(6'b010000, 6'b010000, "R4 ep4 set");
    xact_i[4] = 1;                cyc(6'b010000, 6'b010000, "R5 ep4 latched");
    wr(4, 0);                     cyc(6'b000000, 6'b010000, "R5 status outlives bit");
    feat_clr_i = 1; feat_ep_i = 4; cyc(6'b000000, 6'b000000, "R9 clear feature ep4");

    wr(5, 1);                     cyc(6'b100000, 6'b100000, "R4 ep5 set");
    feat_set_i = 1; feat_ep_i = 5; cyc(6'b100000, 6'b100000, "R8 set feature ep5");
    feat_clr_i = 1; feat_ep_i = 5; cyc(6'b000000, 6'b000000, "R9 hw mode clears both");

    feat_set_i = 1; feat_ep_i = 0;  cyc(6'b000000, 6'b000000, "R10 feature ep0 ignored");
    feat_set_i = 1; feat_ep_i = 7;  cyc(6'b000000, 6'b000000, "R10 feature ep7 ignored");
    feat_set_i = 1; feat_ep_i = 15; cyc(6'b000000, 6'b000000, "R10 feature ep15 ignored");

    wr(1, 1);                     cyc(6'b000010, 6'b000010, "R4 ep1 set");
    xact_i[1] = 1; wr(1, 0);      cyc(6'b000010, 6'b000010, "R11 xact beats write0");
    wr(1, 0);                     cyc(6'b000000, 6'b000010, "R5 hw mode halt held");
    feat_clr_i = 1; feat_ep_i = 1; cyc(6'b000000, 6'b000000, "R9 clear ep1");
    feat_clr_i = 1; feat_ep_i = 1; wr(1, 1);
                                  cyc(6'b000000, 6'b000000, "R11 clear beats write1");

    feat_set_i = 1; feat_clr_i = 1; feat_ep_i = 2;
                                  cyc(6'b000000, 6'b000100, "R8 set wins over clear");
    feat_clr_i = 1; feat_ep_i = 2; cyc(6'b000000, 6'b000000, "R9 clear ep2");

    wr(0, 1); wr(3, 1); feat_set_i = 1; feat_ep_i = 5;
                                  cyc(6'b001001, 6'b101001, "R12 mixed state");
    bus_reset_i = 1;              cyc(6'b000000, 6'b000000, "R1 bus reset clears");
    bus_reset_i = 1; wr(0, 1);    cyc(6'b000000, 6'b000000, "R1 bus reset beats write");

    wr(1, 1);                     cyc(6'b000010, 6'b000010, "R4 ep1 set");
    rst = 1'b1;                   cyc(6'b000000, 6'b000000, "R1 rst clears");
    rst = 1'b0;

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule